// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a snapshot of a free-running 16-bit timer count whenever a chosen edge appears on a trigger signal. The trigger is either an external capture pin or an internal comparator output, picked by a select bit. The trigger passes through a two-stage synchroniser and an optional majority-free noise filter, then through an edge detector with selectable polarity. When a capture occurs, the count is stored in the capture register and an interrupt flag is raised. Software clears the flag by writing a one to it.

Software reaches the 16-bit capture register over an 8-bit bus. A shared high-byte holding register keeps the two halves consistent. Reads take the low byte first, and that read freezes the high byte. Writes put the high byte first, and the low-byte write commits both halves at once. A write only changes the register while the waveform logic is in a mode that uses the register as its TOP value. The current register value is also driven out for that waveform logic. The counter itself is supplied on an input port.

Top module: `tcap_unit`

## Requirements
- R1: A capture copies `cnt_val` into the capture register (visible on `cap_value`) and sets `cap_flag`.
- R2: With `src_sel`=0 only `pin_in` can trigger a capture; with `src_sel`=1 only `cmp_in` can.
- R3: With `edge_rise`=1 only a 0-to-1 transition of the selected trigger captures; with `edge_rise`=0 only a 1-to-0 transition does.
- R4: With the filter off, a trigger change first seen at clock edge k gives a strobe in the cycle after edge k+1, so the stored count is the value present in the cycle two clocks after the change was applied.
- R5: With `filt_en`=1 the filter passes a new level only after four consecutive agreeing samples. This adds exactly four clocks of capture latency, and a pulse shorter than four clocks causes no capture.
- R6: A bus read at address 0 returns the low byte and latches the high byte into the holding register. A read at address 1 returns the holding register, even if a capture has changed the capture register in between.
- R7: A write at address 1 loads the holding register. When `top_mode`=1, a write at address 0 stores {holding, data} into the capture register in a single cycle.
- R8: When `top_mode`=0, a write at address 0 leaves the capture register unchanged.
- R9: Writing a byte with bit 0 set to address 2 clears `cap_flag`. Writing bit 0 as zero has no effect. A read at address 2 returns the flag in bit 0.
- R10: If a capture and a flag-clear write fall in the same cycle, the flag stays set.
- R11: If a capture and a low-byte register write fall in the same cycle, the captured count is stored.
- R12: Changing `src_sel` while the two trigger inputs differ acts as a trigger transition and can capture.
- R13: `bus_rdata` is registered: it holds the selected byte in the cycle after a read strobe and reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current timer count |
| pin_in | input | 1 | External capture trigger (asynchronous) |
| cmp_in | input | 1 | Comparator output trigger (asynchronous) |
| src_sel | input | 1 | Trigger select: 0 pin, 1 comparator |
| edge_rise | input | 1 | Edge polarity: 1 rising, 0 falling |
| filt_en | input | 1 | Noise filter enable |
| top_mode | input | 1 | Waveform mode uses capture register as TOP; enables writes |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_value | output | 16 | Capture register contents (TOP value) |
| cap_flag | output | 1 | Capture interrupt flag |

## Verification
A capture strobe can land in the same cycle as a software flag-clear, or in the same cycle as a low-byte register write. The bench forces each collision by toggling the trigger and then issuing the bus write exactly two clocks later, which is the strobe cycle under R4. For the clear collision, the flag must still read one afterwards. For the write collision, the register must hold the count from the strobe cycle, not the written word. Each outcome is compared against the bench's own computed count.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int TCAP_CNT_W = 16;
  localparam int TCAP_BUS_W = 8;

  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } tcap_addr_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic ff_q;
      always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= d;
      end
      assign q = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int HIST_W = (LEN > 1) ? LEN - 1 : 1;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   window;
  logic              all_hi;
  logic              all_lo;
  logic              out_q;

  generate
    if (LEN > 1) begin : g_hist
      if (HIST_W > 1) begin : g_shift
        always_ff @(posedge clk) begin
          if (rst) hist_q <= '0;
          else     hist_q <= {hist_q[HIST_W-2:0], d};
        end
      end else begin : g_one
        always_ff @(posedge clk) begin
          if (rst) hist_q <= '0;
          else     hist_q <= d;
        end
      end
    end else begin : g_nohist
      always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= d;
      end
    end
  endgenerate

  // newest sample plus the stored ones form the agreement window
  assign window = {hist_q, d};
  assign all_hi = &window;
  assign all_lo = ~|window;

  always_ff @(posedge clk) begin
    if (rst)         out_q <= 1'b0;
    else if (all_hi) out_q <= 1'b1;
    else if (all_lo) out_q <= 1'b0;
  end

  assign q = out_q;
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
  input  logic clk,
  input  logic rst,
  input  logic raw_lvl,
  input  logic filt_lvl,
  input  logic filt_en,
  input  logic edge_rise,
  output logic stb
);
  logic cur_lvl;
  logic prev_q;

  assign cur_lvl = filt_en ? filt_lvl : raw_lvl;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur_lvl;
  end

  assign stb = (cur_lvl != prev_q) && (cur_lvl == edge_rise);
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               top_mode,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  output logic [CNT_W-1:0]   cap_value,
  output logic               cap_flag
);
  localparam int HALF_W = CNT_W / 2;

  tcap_addr_e        addr;
  logic [HALF_W-1:0] temp_q;
  logic [CNT_W-1:0]  cap_q;
  logic              flag_q;
  logic [HALF_W-1:0] rdata_q;
  logic              wr_lo, wr_hi, wr_flag, rd_lo;

  assign addr    = tcap_addr_e'(bus_addr);
  assign wr_lo   = bus_wr && (addr == ADDR_LO);
  assign wr_hi   = bus_wr && (addr == ADDR_HI);
  assign wr_flag = bus_wr && (addr == ADDR_FLAG);
  assign rd_lo   = bus_rd && (addr == ADDR_LO);

  // capture register: capture has priority over a software commit
  always_ff @(posedge clk) begin
    if (rst)                  cap_q <= '0;
    else if (stb)             cap_q <= cnt_val;
    else if (wr_lo && top_mode) cap_q <= {temp_q, bus_wdata};
  end

  // shared high-byte holding register
  always_ff @(posedge clk) begin
    if (rst)        temp_q <= '0;
    else if (wr_hi) temp_q <= bus_wdata;
    else if (rd_lo) temp_q <= cap_q[CNT_W-1:HALF_W];
  end

  // interrupt flag: set wins over clear
  always_ff @(posedge clk) begin
    if (rst)                        flag_q <= 1'b0;
    else if (stb)                   flag_q <= 1'b1;
    else if (wr_flag && bus_wdata[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) begin
      case (addr)
        ADDR_LO:   rdata_q <= cap_q[HALF_W-1:0];
        ADDR_HI:   rdata_q <= temp_q;
        ADDR_FLAG: rdata_q <= {{(HALF_W-1){1'b0}}, flag_q};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign cap_value = cap_q;
  assign cap_flag  = flag_q;
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W       = TCAP_CNT_W,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               pin_in,
  input  logic               cmp_in,
  input  logic               src_sel,
  input  logic               edge_rise,
  input  logic               filt_en,
  input  logic               top_mode,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  output logic [CNT_W-1:0]   cap_value,
  output logic               cap_flag
);
  logic trig_raw;
  logic trig_sync;
  logic trig_filt;
  logic cap_stb;

  // source mux sits ahead of the synchroniser, so a select change is an edge
  assign trig_raw = src_sel ? cmp_in : pin_in;

  tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (trig_raw),
    .q   (trig_sync)
  );

  tcap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk (clk),
    .rst (rst),
    .d   (trig_sync),
    .q   (trig_filt)
  );

  tcap_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .raw_lvl   (trig_sync),
    .filt_lvl  (trig_filt),
    .filt_en   (filt_en),
    .edge_rise (edge_rise),
    .stb       (cap_stb)
  );

  tcap_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .stb       (cap_stb),
    .cnt_val   (cnt_val),
    .top_mode  (top_mode),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_value (cap_value),
    .cap_flag  (cap_flag)
  );
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cap_stb,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             edge_rise,
  input logic             top_mode,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             clr_bit
);
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_value == $past(cnt_val)); // R1
  AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> cap_flag); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cap_stb |=> (!cap_stb || edge_rise != $past(edge_rise))); // R4
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && !top_mode && !cap_stb) |=> $stable(cap_value)); // R8
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && clr_bit && !cap_stb) |=> !cap_flag); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && bus_wr && bus_addr == 2'd2) |=> cap_flag); // R10
  AST_CAPTURE_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && bus_wr && bus_addr == 2'd0) |=> cap_value == $past(cnt_val)); // R11
  AST_VALUE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cap_stb && !bus_wr) |=> $stable(cap_value)); // R7
endmodule

bind tcap_unit tcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cap_stb   (cap_stb),
  .cnt_val   (cnt_val),
  .cap_value (cap_value),
  .cap_flag  (cap_flag),
  .edge_rise (edge_rise),
  .top_mode  (top_mode),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .clr_bit   (bus_wdata[0])
);

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [31:0]      cyc = 32'd0;
  logic [CNT_W-1:0] cnt_val;
  logic pin_in = 0, cmp_in = 0, src_sel = 0, edge_rise = 1, filt_en = 0, top_mode = 0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [CNT_W-1:0] cap_value;
  logic cap_flag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 32'd1;
  assign cnt_val = cyc[CNT_W-1:0];

  tcap_unit u_dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_sel(src_sel), .edge_rise(edge_rise), .filt_en(filt_en), .top_mode(top_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_value(cap_value), .cap_flag(cap_flag)
  );

  // expected count: change seen two clocks later, plus four when filtered
  function automatic logic [15:0] exp_count(logic [15:0] c, logic filt);
    return c + 16'd2 + (filt ? 16'd4 : 16'd0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt(); @(negedge clk); endtask
  task automatic idle(int n); repeat (n) nxt(); endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; nxt(); bus_wr = 0;
  endtask

  task automatic read_byte(logic [1:0] a, output logic [7:0] v);
    bus_rd = 1; bus_addr = a; nxt(); v = bus_rdata; bus_rd = 0;
  endtask

  task automatic read16(output logic [15:0] v);
    bus_rd = 1; bus_addr = 2'd0; nxt(); v[7:0] = bus_rdata;
    bus_addr = 2'd1; nxt(); v[15:8] = bus_rdata; bus_rd = 0;
  endtask

  task automatic drive_trig(logic on_cmp, logic lvl, output logic [15:0] expv);
    expv = exp_count(cyc[15:0], filt_en);
    if (on_cmp) cmp_in = lvl; else pin_in = lvl;
    idle(12);
  endtask

  task automatic clear_flag(); bus_write(2'd2, 8'h01); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] expv, got, cap_a, cap_b;
    logic [7:0]  b;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst = 0;
    nxt();
    chk("R13 reset rdata", bus_rdata, 0);
    chk("R1 reset value", cap_value, 0);
    chk("R1 reset flag", cap_flag, 0);
    idle(6);

    // R1 R4: rising pin edge, no filter
    drive_trig(0, 1, expv);
    read16(got);
    chk("R4 capture count", got, expv);
    chk("R1 port value", cap_value, expv);
    chk("R1 flag set", cap_flag, 1);
    read_byte(2'd2, b);
    chk("R9 flag readback", b, 8'h01);

    // R3: falling edge ignored while rising selected
    clear_flag();
    cap_a = cap_value;
    drive_trig(0, 0, expv);
    chk("R3 opposite edge no flag", cap_flag, 0);
    chk("R3 opposite edge no value", cap_value, cap_a);
    edge_rise = 0; idle(3);
    drive_trig(0, 1, expv);
    chk("R3 rising ignored when falling chosen", cap_flag, 0);
    drive_trig(0, 0, expv);
    chk("R3 falling capture", cap_value, expv);
    chk("R3 falling flag", cap_flag, 1);

    // R2: comparator selected, pin ignored
    edge_rise = 1; src_sel = 1; idle(6); clear_flag();
    drive_trig(0, 1, expv);
    chk("R2 pin ignored", cap_flag, 0);
    drive_trig(1, 1, expv);
    chk("R2 comparator capture", cap_value, expv);
    chk("R2 comparator flag", cap_flag, 1);

    // R12: source switch with differing levels gives a capture
    src_sel = 0; idle(6);             // pin=1 cmp=1
    cmp_in = 0; idle(6); clear_flag();
    edge_rise = 0; idle(3);
    chk("R12 quiet before switch", cap_flag, 0);
    expv = exp_count(cyc[15:0], 0);
    src_sel = 1; idle(12);            // selected level falls 1 -> 0
    chk("R12 switch capture value", cap_value, expv);
    chk("R12 switch capture flag", cap_flag, 1);

    // R5: filtered latency and short pulse rejection (cmp selected, now 0)
    edge_rise = 1; filt_en = 1; idle(8); clear_flag();
    drive_trig(1, 1, expv);
    chk("R5 filtered latency", cap_value, expv);
    clear_flag(); edge_rise = 0; idle(2);
    cap_a = cap_value;
    cmp_in = 0; idle(3); cmp_in = 1; idle(12);
    chk("R5 short pulse flag", cap_flag, 0);
    chk("R5 short pulse value", cap_value, cap_a);

    // R6: high-byte read returns the holding register
    filt_en = 0; src_sel = 0; edge_rise = 1; idle(6);   // pin=1
    pin_in = 0; idle(8);
    drive_trig(0, 1, cap_a);
    read_byte(2'd0, b);
    chk("R6 low byte", b, cap_a[7:0]);
    idle(300);
    pin_in = 0; idle(8);
    drive_trig(0, 1, cap_b);
    chk("R6 later capture differs", cap_value, cap_b);
    read_byte(2'd1, b);
    chk("R6 high byte from holding", b, cap_a[15:8]);

    // R8 / R7: writes gated by mode
    top_mode = 0;
    bus_write(2'd1, 8'h5A); bus_write(2'd0, 8'hC3); idle(2);
    read16(got);
    chk("R8 write ignored", got, cap_b);
    top_mode = 1;
    bus_write(2'd1, 8'h5A); bus_write(2'd0, 8'hC3); idle(2);
    chk("R7 TOP port", cap_value, 16'h5AC3);
    read16(got);
    chk("R7 TOP readback", got, 16'h5AC3);
    top_mode = 0;

    // R10: capture and clear in the same cycle (flag already set)
    chk("R10 flag set before", cap_flag, 1);
    pin_in = 0; idle(8);
    expv = exp_count(cyc[15:0], 0);
    pin_in = 1; nxt(); nxt();
    bus_write(2'd2, 8'h01); idle(4);
    chk("R10 flag survives clear", cap_flag, 1);
    chk("R10 value", cap_value, expv);

    // R9: zero write no effect, one write clears
    bus_write(2'd2, 8'hFE); idle(1);
    chk("R9 zero bit no clear", cap_flag, 1);
    bus_write(2'd2, 8'h01); idle(1);
    chk("R9 clear", cap_flag, 0);

    // R11: capture beats low-byte commit
    top_mode = 1;
    bus_write(2'd1, 8'h77);
    pin_in = 0; idle(8);
    expv = exp_count(cyc[15:0], 0);
    pin_in = 1; nxt(); nxt();
    bus_write(2'd0, 8'h11); idle(4);
    chk("R11 capture wins", cap_value, expv);
    top_mode = 0;

    // random mix over source, polarity and filter (R1 R2 R3 R4 R5)
    for (int i = 0; i < 24; i++) begin
      logic s, r, f;
      s = 1'($urandom_range(0, 1));
      r = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      filt_en = f; edge_rise = r;
      pin_in = ~r; cmp_in = ~r; idle(2);
      src_sel = s; idle(14);
      clear_flag();
      idle($urandom_range(0, 40));
      drive_trig(s, r, expv);
      read16(got);
      chk("R4 random capture count", got, expv);
      chk("R1 random flag", cap_flag, 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule